// File: doc/BRIEF.md
# CPU Doze Clock-Enable Controller

This block lets a CPU core run slower than the system clock while every peripheral keeps running at the full rate. There is no second clock. The core and the peripherals share one system clock. The block drives a per-cycle clock enable for the core and a peripheral enable that is always high. The system clock source and its frequency never change.

A single 16-bit control register sets three things:
- whether the reduced rate is active,
- a 3-bit exponent N, which gives a core-to-peripheral rate of 1:2^N (1:1 up to 1:128),
- whether a pending interrupt should drop the core back to full speed.

The divider is a 7-bit free-running phase counter. The core enable fires whenever the low N bits of that counter are zero. A write that changes the exponent or the enable bit restarts the counter, so the core gets an enable on the very next cycle.

The reset input is asynchronous and active low. It is expected to be released synchronously to the clock upstream of this block.

Top module: `doze_ratio_ctrl`

## Requirements
- R1: The register maps the return-on-interrupt bit to bit 15, the rate exponent N to bits 14:12 and the doze enable to bit 11. `rd_data` shows these fields. Bits 10:0 always read zero, and writes to them are ignored.
- R2: During reset and after it, the enable, the exponent and the return-on-interrupt bit are all zero, `rd_data` is zero and `cpu_ce` is high on every cycle.
- R3: A write with `wr_en` high at a rising edge shows in `rd_data` from the cycle that follows that edge.
- R4: While the doze enable is zero, `cpu_ce` is high on every cycle, whatever the exponent holds.
- R5: While the doze enable is one, `cpu_ce` is high only in cycles where the low N bits of the phase counter are zero, which is one cycle in every 2^N. The phase counter is 7 bits wide, resets to zero, counts up by one every cycle and wraps from 127 to 0.
- R6: When a write changes the exponent or the enable bit, the phase counter is zero in the cycle after the write edge, so `cpu_ce` is high in that cycle. A write that leaves both unchanged does not disturb the counter, even if it changes bit 15.
- R7: `per_ce` is high on every cycle.
- R8: The stored return-on-interrupt bit is checked at each rising edge. If it is one while `irq_pend` is high, the doze enable is cleared at that edge. This happens even if a write in the same cycle sets the enable. From the next cycle `cpu_ce` is high on every cycle.
- R9: While the stored return-on-interrupt bit is zero, `irq_pend` has no effect on the register or on `cpu_ce`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock shared by the core and the peripherals |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write value |
| rd_data | output | 16 | Register readback |
| irq_pend | input | 1 | An interrupt request is pending |
| cpu_ce | output | 1 | Core clock enable for this cycle |
| per_ce | output | 1 | Peripheral clock enable, always high |

## Verification
A write or an interrupt at a rising edge is visible one cycle later. That edge updates the register, so `rd_data` and `cpu_ce` change in the cycle after it. `cpu_ce` itself is combinational from the stored state, so it belongs to the cycle in which it is sampled.

The bench drives inputs and samples outputs at the falling edge, then applies the inputs. Its own model (the fields plus a phase count) is advanced only at the following rising edge. This keeps every expected value aligned with the cycle in which the block's registers actually hold it.

// File: rtl/doze_pkg.sv
package doze_pkg;
  localparam int REG_W     = 16;
  localparam int EN_POS    = 11;
  localparam int RATIO_LSB = 12;
  localparam int RATIO_W   = 3;
  localparam int ROI_POS   = 15;
  localparam int PHASE_W   = 7;

  typedef struct packed {
    logic               roi;
    logic [RATIO_W-1:0] ratio;
    logic               en;
  } doze_cfg_t;
endpackage

// File: rtl/doze_ctrl_reg.sv
module doze_ctrl_reg
  import doze_pkg::*;
#(
  parameter int DW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          irq_pend,
  output doze_cfg_t     cfg_q,
  output logic          restart
);
  doze_cfg_t cfg_d;
  doze_cfg_t wr_cfg;

  always_comb begin
    wr_cfg.roi   = wr_data[ROI_POS];
    wr_cfg.ratio = wr_data[RATIO_LSB +: RATIO_W];
    wr_cfg.en    = wr_data[EN_POS];
  end

  // Restart the phase counter only when the rate-setting fields change.
  assign restart = wr_en && ({wr_cfg.ratio, wr_cfg.en} != {cfg_q.ratio, cfg_q.en});

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) cfg_d = wr_cfg;
    // An interrupt return overrides a same-cycle write that sets the enable.
    if (cfg_q.roi && irq_pend) cfg_d.en = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  // R8
  irq_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.roi && irq_pend) |=> !cfg_q.en);

  // R9
  irq_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q.roi && irq_pend && !wr_en) |=> $stable(cfg_q));
endmodule

// File: rtl/doze_phase_cnt.sv
module doze_phase_cnt #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  output logic [CW-1:0] cnt_q
);
  logic [CW-1:0] cnt_d;

  always_comb begin
    if (restart) cnt_d = '0;
    else         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R5
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> cnt_q == CW'($past(cnt_q) + 1'b1));
endmodule

// File: rtl/doze_ce_gen.sv
module doze_ce_gen #(
  parameter int CW = 7,
  parameter int RW = 3
) (
  input  logic          en,
  input  logic [RW-1:0] ratio,
  input  logic [CW-1:0] cnt,
  output logic          cpu_ce
);
  logic [CW-1:0] mask;

  // Bit i of the mask is set when the exponent is above i.
  for (genvar i = 0; i < CW; i++) begin : g_mask
    assign mask[i] = (RW'(i) < ratio);
  end

  assign cpu_ce = !en || ((cnt & mask) == '0);
endmodule

// File: rtl/doze_ratio_ctrl.sv
module doze_ratio_ctrl
  import doze_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             irq_pend,
  output logic             cpu_ce,
  output logic             per_ce
);
  doze_cfg_t          cfg_q;
  logic               restart;
  logic [PHASE_W-1:0] phase;

  doze_ctrl_reg #(.DW(REG_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .irq_pend(irq_pend), .cfg_q(cfg_q), .restart(restart)
  );

  doze_phase_cnt #(.CW(PHASE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(restart), .cnt_q(phase)
  );

  doze_ce_gen #(.CW(PHASE_W), .RW(RATIO_W)) u_ce (
    .en(cfg_q.en), .ratio(cfg_q.ratio), .cnt(phase), .cpu_ce(cpu_ce)
  );

  always_comb begin
    rd_data                            = '0;
    rd_data[ROI_POS]                   = cfg_q.roi;
    rd_data[RATIO_LSB +: RATIO_W]      = cfg_q.ratio;
    rd_data[EN_POS]                    = cfg_q.en;
  end

  assign per_ce = 1'b1;

  // R3
  ratio_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[RATIO_LSB +: RATIO_W] == $past(wr_data[RATIO_LSB +: RATIO_W]));

  // R4
  full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[EN_POS] |-> cpu_ce);

  // R6
  restart_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_data[14:11] != rd_data[14:11])) |=> cpu_ce);
endmodule

// File: tb/sim_doze_ratio_ctrl.sv
module sim_doze_ratio_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic        irq_pend;
  logic        cpu_ce;
  logic        per_ce;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string ctx = "";

  // Bench model of the register and of the phase count.
  logic       m_en, m_roi;
  logic [2:0] m_ratio;
  int         m_phase;

  always #10 clk = ~clk;

  doze_ratio_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq_pend(irq_pend), .cpu_ce(cpu_ce), .per_ce(per_ce)
  );

  function automatic logic exp_ce(logic en, logic [2:0] n, int ph);
    return !en || ((ph % (1 << n)) == 0);
  endfunction

  function automatic logic [15:0] exp_rd(logic roi, logic [2:0] n, logic en);
    return {roi, n, en, 11'b0};
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s%s: actual %h expected %h at %0t", tag, ctx, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    chk("R1", rd_data, exp_rd(m_roi, m_ratio, m_en));
    chk(m_en ? "R5" : "R4", {15'b0, cpu_ce}, {15'b0, exp_ce(m_en, m_ratio, m_phase)});
    chk("R7", {15'b0, per_ce}, 16'h1);
  endtask

  // One cycle: check at the falling edge, drive, then advance the model at the rising edge.
  task automatic cyc(logic w, logic [15:0] d, logic irq);
    logic chg;
    @(negedge clk);
    check_outputs();
    wr_en = w; wr_data = d; irq_pend = irq;
    @(posedge clk);
    chg = w && ({d[14:12], d[11]} != {m_ratio, m_en});
    if (w) begin m_roi = d[15]; m_ratio = d[14:12]; m_en = d[11]; end
    if (irq && (w ? 1'b1 : 1'b1) && roi_before) m_en = 1'b0;
    m_phase = chg ? 0 : (m_phase + 1) % 128;
    roi_before = m_roi;
  endtask

  logic roi_before;

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 16'h0, 1'b0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd1234);
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; irq_pend = 1'b0;
    m_en = 0; m_roi = 0; m_ratio = 0; m_phase = 0; roi_before = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    ctx = " R2";
    check_outputs();
    rst_n = 1'b1;
    // Reset state holds with no writes.
    idle(5);

    // R3 / R6: enable with exponent 3, unused bits set and ignored (R1).
    ctx = " R6";
    cyc(1'b1, 16'h3FFF, 1'b0);
    idle(20);
    // R6: same rate fields, only roi changes -> no restart.
    ctx = " R6 no-restart";
    cyc(1'b1, 16'hB800 | 16'h07FF, 1'b0);
    idle(10);
    // R5: largest exponent, across a counter wrap.
    ctx = " R5 n7";
    cyc(1'b1, 16'h7800, 1'b0);
    idle(260);
    // R4: exponent left at 7 but enable clear.
    ctx = " R4";
    cyc(1'b1, 16'h7000, 1'b0);
    idle(12);
    // R9: roi clear, interrupt ignored.
    ctx = " R9";
    cyc(1'b1, 16'h2800, 1'b0);
    idle(3);
    cyc(1'b0, 16'h0, 1'b1);
    cyc(1'b0, 16'h0, 1'b1);
    idle(6);
    // R8: roi set, interrupt clears the enable.
    ctx = " R8";
    cyc(1'b1, 16'hA800, 1'b0);
    idle(3);
    cyc(1'b0, 16'h0, 1'b1);
    idle(6);
    // R8: write setting the enable in the same cycle as the interrupt loses.
    cyc(1'b1, 16'hC800, 1'b1);
    idle(6);

    // Random mix.
    ctx = " rnd";
    for (int i = 0; i < 3000; i++) begin
      logic w, q;
      w = ($urandom % 8) == 0;
      q = ($urandom % 16) == 0;
      cyc(w, 16'($urandom), q);
    end
    @(negedge clk);
    check_outputs();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule